// File: doc/BRIEF.md
# PHY Timing-Mode and DLL Setup Sequencer

This block reconfigures an SD/eMMC host PHY whenever the bus clock changes. A caller presents a bus timing mode, the new bus clock rate in MHz and a pad drive type, then pulses `start`. The sequencer issues single-cycle accesses on a simple byte-wide register port. It sets the PHY mode register, refreshes the pad drive field where the mode calls for it, and programs both tap delays and the DLL trim. It then clears the DLL and re-enables it at a frequency band derived from the clock rate.

Every mode except legacy then waits for the DLL to report lock. The wait polls the DLL status register once per cycle and gives up after a bounded number of reads. If the requested rate matches the last rate applied, the whole sequence is skipped and `done` pulses at once. A request that ends in a timeout still counts as applied.

The register port returns read data combinationally in the cycle the read is issued. Writes take effect at the clock edge that ends the write cycle.

Top module: `phy_mode_seq`

## Requirements
- R1: The mode input is encoded as legacy=0, HS=1, HS200=2, DDR=3, HS400=4, enhanced strobe=5. The first write of a sequence goes to address 0x11 with the value enhanced strobe=0x01, HS400=0x02, legacy=0x04, DDR=0x08, and 0x00 for both HS and HS200.
- R2: Only in HS400 and HS200 does the sequencer read address 0x01 and then write back the value read, ORed with the 2-bit drive type shifted left by 2. No other mode touches 0x01.
- R3: Address 0x0D (output tap) receives 0 in legacy mode. In every other mode it receives (tap << 1) | 1, where tap is HS=3, HS200=2, DDR=1, HS400=1, enhanced strobe=1.
- R4: Address 0x0C (input tap) receives 0 in legacy and in HS200. In every other mode it receives (tap << 1) | 1, where tap is HS=2, HS400=0xA, DDR=0, enhanced strobe=0.
- R5: Address 0x12 (DLL trim) receives the trim value (default 0x08) in every mode except legacy, where it is not written.
- R6: Address 0x00 (DLL status) is always written with 0 first. In legacy mode the sequence ends right after that write. In other modes it is then written with (code << 5) | 0x08.
- R7: After the DLL enable write, address 0x00 is read every cycle until bit 4 is set. `done` follows in the next cycle with `error` low.
- R8: The DLL frequency code is 0 for 200 MHz, 2 for 100 MHz, 1 for 50 MHz, and 0 for any other rate.
- R9: When `start` arrives with the same rate as the last applied request, no register access is made. `done` pulses in the next cycle and `error` reads 0.
- R10: If bit 4 is not seen within POLL_LIMIT reads, `done` pulses with `error` high. The rate is still recorded as applied, and `error` holds until the next `start`.
- R11: `busy` is high from the cycle after an accepted `start` until `done`. `done` lasts one cycle. A `start` that arrives while busy is ignored.
- R12: Writes occur in the order: mode, pad, output tap, input tap, trim, DLL clear, DLL enable, with the skipped steps left out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| reqMode | input | 3 | Bus timing mode (encoding in R1) |
| reqRate | input | RATE_W | Requested bus clock in MHz |
| reqDrv | input | 2 | Pad drive type |
| regAddr | output | 8 | Register port address |
| regWrData | output | 8 | Register port write data |
| regWe | output | 1 | Register write strobe |
| regRe | output | 1 | Register read strobe |
| regRdData | input | 8 | Register read data, same cycle as regRe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | DLL lock timeout on the last request |

## Verification
The bench steps through all six modes, using the 200, 100 and 50 MHz rates and two other rates. This separates the per-mode tap and mode values from the rate-to-code mapping, and it exposes the HS200 input-tap exception and the legacy short path. Two HS-class runs use different drive values against a preset pad byte, so a missing read-modify-write or a wrong shift shows up. A repeated rate, a run whose DLL never locks followed by the same rate again, and a start pulse injected mid-run cover the skip rule, the timeout recording and the busy lockout. The bench compares every register write against its own expected queue as the write happens.

// File: rtl/phy_mode_seq_pkg.sv
package phy_mode_seq_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int DRV_W  = 2;
  localparam int CODE_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DLL  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_PAD  = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_ITAP = 8'h0C;
  localparam logic [ADDR_W-1:0] ADDR_OTAP = 8'h0D;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h11;
  localparam logic [ADDR_W-1:0] ADDR_TRIM = 8'h12;

  localparam int DLL_EN_BIT  = 3;
  localparam int DLL_RDY_BIT = 4;
  localparam int CODE_SHIFT  = 5;
  localparam int DRV_SHIFT   = 2;

  typedef enum logic [2:0] {
    MODE_LEGACY  = 3'd0,
    MODE_HS      = 3'd1,
    MODE_HS200   = 3'd2,
    MODE_DDR     = 3'd3,
    MODE_HS400   = 3'd4,
    MODE_ESTROBE = 3'd5
  } busMode_e;

  typedef enum logic [2:0] {
    STEP_MODE,
    STEP_PAD,
    STEP_OTAP,
    STEP_ITAP,
    STEP_TRIM,
    STEP_DLLCLR,
    STEP_DLLEN,
    STEP_POLL
  } step_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  wr;
    logic  rd;
    step_e step;
    logic  latchReq;
    logic  clrErr;
    logic  setErr;
    logic  padCap;
    logic  pollInc;
  } seqStrobe_t;

  function automatic logic [DATA_W-1:0] modeRegVal(busMode_e m);
    case (m)
      MODE_ESTROBE: return 8'h01;
      MODE_HS400:   return 8'h02;
      MODE_LEGACY:  return 8'h04;
      MODE_DDR:     return 8'h08;
      default:      return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] outTapOf(busMode_e m);
    case (m)
      MODE_HS:      return 4'd3;
      MODE_HS200:   return 4'd2;
      MODE_DDR,
      MODE_HS400,
      MODE_ESTROBE: return 4'd1;
      default:      return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] inTapOf(busMode_e m);
    case (m)
      MODE_HS:    return 4'd2;
      MODE_HS400: return 4'hA;
      default:    return 4'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] tapWord(logic [3:0] tap);
    return {3'b000, tap, 1'b1};
  endfunction

endpackage

// File: rtl/phy_mode_seq_dp.sv
module phy_mode_seq_dp
  import phy_mode_seq_pkg::*;
#(
  parameter int RATE_W     = 10,
  parameter int POLL_LIMIT = 64,
  parameter int TRIM_VAL   = 8,
  parameter int RATE_FAST  = 200,
  parameter int RATE_MID   = 100,
  parameter int RATE_SLOW  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        stb,
  input  logic [2:0]        reqMode,
  input  logic [RATE_W-1:0] reqRate,
  input  logic [DRV_W-1:0]  reqDrv,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWe,
  output logic              regRe,
  output logic              sameClk,
  output busMode_e          curMode,
  output logic              dllReady,
  output logic              pollExpired,
  output logic              error
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_LIMIT - 1);

  logic [RATE_W-1:0] lastRate;
  logic              lastValid;
  busMode_e          modeQ;
  logic [DRV_W-1:0]  drvQ;
  logic [CODE_W-1:0] codeQ;
  logic [DATA_W-1:0] padQ;
  logic [CNT_W-1:0]  pollCnt;
  logic              errQ;
  logic [CODE_W-1:0] codeNext;
  logic              isLegacy;

  always_comb begin
    if (reqRate == RATE_W'(RATE_FAST))      codeNext = 2'd0;
    else if (reqRate == RATE_W'(RATE_MID))  codeNext = 2'd2;
    else if (reqRate == RATE_W'(RATE_SLOW)) codeNext = 2'd1;
    else                                    codeNext = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastRate  <= '0;
      lastValid <= 1'b0;
      modeQ     <= MODE_LEGACY;
      drvQ      <= '0;
      codeQ     <= '0;
    end else if (stb.latchReq) begin
      lastRate  <= reqRate;
      lastValid <= 1'b1;
      modeQ     <= busMode_e'(reqMode);
      drvQ      <= reqDrv;
      codeQ     <= codeNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          padQ <= '0;
    else if (stb.padCap) padQ <= regRdData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pollCnt <= '0;
    else if (stb.latchReq) pollCnt <= '0;
    else if (stb.pollInc)  pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          errQ <= 1'b0;
    else if (stb.clrErr) errQ <= 1'b0;
    else if (stb.setErr) errQ <= 1'b1;
  end

  assign isLegacy = (modeQ == MODE_LEGACY);

  always_comb begin
    regAddr   = ADDR_DLL;
    regWrData = '0;
    case (stb.step)
      STEP_MODE: begin
        regAddr   = ADDR_MODE;
        regWrData = modeRegVal(modeQ);
      end
      STEP_PAD: begin
        regAddr   = ADDR_PAD;
        regWrData = padQ | (DATA_W'(drvQ) << DRV_SHIFT);
      end
      STEP_OTAP: begin
        regAddr   = ADDR_OTAP;
        regWrData = isLegacy ? '0 : tapWord(outTapOf(modeQ));
      end
      STEP_ITAP: begin
        regAddr   = ADDR_ITAP;
        regWrData = (isLegacy || modeQ == MODE_HS200) ? '0 : tapWord(inTapOf(modeQ));
      end
      STEP_TRIM: begin
        regAddr   = ADDR_TRIM;
        regWrData = DATA_W'(TRIM_VAL);
      end
      STEP_DLLCLR: begin
        regAddr   = ADDR_DLL;
        regWrData = '0;
      end
      STEP_DLLEN: begin
        regAddr   = ADDR_DLL;
        regWrData = (DATA_W'(codeQ) << CODE_SHIFT) | (DATA_W'(1) << DLL_EN_BIT);
      end
      default: begin
        regAddr   = ADDR_DLL;
        regWrData = '0;
      end
    endcase
  end

  assign regWe       = stb.wr;
  assign regRe       = stb.rd;
  assign sameClk     = lastValid && (reqRate == lastRate);
  assign curMode     = modeQ;
  assign dllReady    = regRdData[DLL_RDY_BIT];
  assign pollExpired = (pollCnt == CNT_LAST);
  assign error       = errQ;

  AST_TIMEOUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.setErr |=> error); // R10
  AST_POLL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pollInc |-> pollCnt <= CNT_LAST); // R10
  AST_NO_TRIM_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == ADDR_TRIM) |-> !isLegacy); // R5
  AST_PAD_HS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((regWe || regRe) && regAddr == ADDR_PAD) |-> (modeQ == MODE_HS400 || modeQ == MODE_HS200)); // R2

endmodule

// File: rtl/phy_mode_seq_ctrl.sv
module phy_mode_seq_ctrl
  import phy_mode_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sameClk,
  input  busMode_e   curMode,
  input  logic       dllReady,
  input  logic       pollExpired,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_MODE, S_PADRD, S_PADWR, S_OTAP, S_ITAP,
    S_TRIM, S_DLLCLR, S_DLLEN, S_POLL, S_FINISH
  } state_e;

  state_e state, stateNext;
  logic   padMode;
  logic   legacy;

  assign padMode = (curMode == MODE_HS400) || (curMode == MODE_HS200);
  assign legacy  = (curMode == MODE_LEGACY);

  always_comb begin
    stb       = '0;
    stb.step  = STEP_MODE;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.clrErr = 1'b1;
          if (sameClk) begin
            stateNext = S_FINISH;
          end else begin
            stb.latchReq = 1'b1;
            stateNext    = S_MODE;
          end
        end
      end
      S_MODE: begin
        stb.wr    = 1'b1;
        stb.step  = STEP_MODE;
        stateNext = padMode ? S_PADRD : S_OTAP;
      end
      S_PADRD: begin
        stb.rd     = 1'b1;
        stb.step   = STEP_PAD;
        stb.padCap = 1'b1;
        stateNext  = S_PADWR;
      end
      S_PADWR: begin
        stb.wr    = 1'b1;
        stb.step  = STEP_PAD;
        stateNext = S_OTAP;
      end
      S_OTAP: begin
        stb.wr    = 1'b1;
        stb.step  = STEP_OTAP;
        stateNext = S_ITAP;
      end
      S_ITAP: begin
        stb.wr    = 1'b1;
        stb.step  = STEP_ITAP;
        stateNext = legacy ? S_DLLCLR : S_TRIM;
      end
      S_TRIM: begin
        stb.wr    = 1'b1;
        stb.step  = STEP_TRIM;
        stateNext = S_DLLCLR;
      end
      S_DLLCLR: begin
        stb.wr    = 1'b1;
        stb.step  = STEP_DLLCLR;
        stateNext = legacy ? S_FINISH : S_DLLEN;
      end
      S_DLLEN: begin
        stb.wr    = 1'b1;
        stb.step  = STEP_DLLEN;
        stateNext = S_POLL;
      end
      S_POLL: begin
        stb.rd      = 1'b1;
        stb.step    = STEP_POLL;
        stb.pollInc = 1'b1;
        if (dllReady) begin
          stateNext = S_FINISH;
        end else if (pollExpired) begin
          stb.setErr = 1'b1;
          stateNext  = S_FINISH;
        end
      end
      S_FINISH: stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNext;
  end

  assign done = (state == S_FINISH);
  assign busy = (state != S_IDLE) && (state != S_FINISH);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && sameClk) |=> (done && !stb.wr && !stb.rd)); // R9
  AST_LEGACY_ENDS_AT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DLLCLR && legacy) |=> done); // R6
  AST_BUSY_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stb.rd && !stb.wr) |-> 1'b0); // R11
  AST_POLL_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wr && stb.step == STEP_DLLEN) |=> (stb.rd && stb.step == STEP_POLL)); // R7

endmodule

// File: rtl/phy_mode_seq.sv
module phy_mode_seq
  import phy_mode_seq_pkg::*;
#(
  parameter int RATE_W     = 10,
  parameter int POLL_LIMIT = 64,
  parameter int TRIM_VAL   = 8,
  parameter int RATE_FAST  = 200,
  parameter int RATE_MID   = 100,
  parameter int RATE_SLOW  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        reqMode,
  input  logic [RATE_W-1:0] reqRate,
  input  logic [1:0]        reqDrv,
  output logic [7:0]        regAddr,
  output logic [7:0]        regWrData,
  output logic              regWe,
  output logic              regRe,
  input  logic [7:0]        regRdData,
  output logic              busy,
  output logic              done,
  output logic              error
);

  seqStrobe_t stb;
  logic       sameClk;
  busMode_e   curMode;
  logic       dllReady;
  logic       pollExpired;

  phy_mode_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sameClk     (sameClk),
    .curMode     (curMode),
    .dllReady    (dllReady),
    .pollExpired (pollExpired),
    .stb         (stb),
    .busy        (busy),
    .done        (done)
  );

  phy_mode_seq_dp #(
    .RATE_W     (RATE_W),
    .POLL_LIMIT (POLL_LIMIT),
    .TRIM_VAL   (TRIM_VAL),
    .RATE_FAST  (RATE_FAST),
    .RATE_MID   (RATE_MID),
    .RATE_SLOW  (RATE_SLOW)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .reqMode     (reqMode),
    .reqRate     (reqRate),
    .reqDrv      (reqDrv),
    .regRdData   (regRdData),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regWe       (regWe),
    .regRe       (regRe),
    .sameClk     (sameClk),
    .curMode     (curMode),
    .dllReady    (dllReady),
    .pollExpired (pollExpired),
    .error       (error)
  );

endmodule

// File: tb/phy_mode_seq_tb_top.sv
module phy_mode_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DLL_DELAY  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] reqMode = 3'd0;
  logic [9:0] reqRate = '0;
  logic [1:0] reqDrv = '0;
  logic [7:0] regAddr, regWrData, regRdData;
  logic       regWe, regRe, busy, done, error;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mode_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .reqMode(reqMode),
    .reqRate(reqRate), .reqDrv(reqDrv), .regAddr(regAddr),
    .regWrData(regWrData), .regWe(regWe), .regRe(regRe),
    .regRdData(regRdData), .busy(busy), .done(done), .error(error)
  );

  // Register file and DLL model
  logic [7:0] regFile [0:255];
  int         dllCnt;
  bit         dllNever = 1'b0;

  assign regRdData = regFile[regAddr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regFile[i] <= 8'h00;
      regFile[1] <= 8'h41;
      dllCnt <= 0;
    end else if (regWe) begin
      regFile[regAddr] <= regWrData;
      if (regAddr == 8'h00 && regWrData[3] && !dllNever) dllCnt <= DLL_DELAY;
      else if (regAddr == 8'h00) dllCnt <= 0;
    end else if (dllCnt > 1) begin
      dllCnt <= dllCnt - 1;
    end else if (dllCnt == 1) begin
      regFile[0] <= regFile[0] | 8'h10;
      dllCnt <= 0;
    end
  end

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  logic [7:0] expAddr [$];
  logic [7:0] expData [$];
  string      expTag  [$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] a, logic [7:0] d, string tag);
    expAddr.push_back(a);
    expData.push_back(d);
    expTag.push_back(tag);
  endtask

  // Reference model: compare every write as it happens
  always @(negedge clk) begin
    if (rst_n && regWe) begin
      if (expAddr.size() == 0) begin
        check(1'b0, "R12", "unexpected write addr", int'(regAddr), 0);
      end else begin
        automatic logic [7:0] a = expAddr.pop_front();
        automatic logic [7:0] d = expData.pop_front();
        automatic string      t = expTag.pop_front();
        check(regAddr == a, "R12", "write address", int'(regAddr), int'(a));
        check(regWrData == d, t, "write data", int'(regWrData), int'(d));
      end
    end
  end

  function automatic logic [3:0] otapRef(int m);
    case (m) 1: return 3; 2: return 2; 3, 4, 5: return 1; default: return 0; endcase
  endfunction
  function automatic logic [3:0] itapRef(int m);
    case (m) 1: return 2; 4: return 4'hA; default: return 0; endcase
  endfunction
  function automatic logic [7:0] modeRef(int m);
    case (m) 5: return 8'h01; 4: return 8'h02; 0: return 8'h04; 3: return 8'h08; default: return 8'h00; endcase
  endfunction
  function automatic int codeRef(int r);
    if (r == 200) return 0;
    if (r == 100) return 2;
    if (r == 50)  return 1;
    return 0;
  endfunction

  task automatic runSeq(int m, int r, int drv, bit skip, bit expErr, bit poke, string tag);
    if (!skip) begin
      push(8'h11, modeRef(m), "R1");
      if (m == 2 || m == 4) push(8'h01, regFile[1] | 8'(drv << 2), "R2");
      push(8'h0D, (m == 0) ? 8'h00 : {3'b0, otapRef(m), 1'b1}, "R3");
      push(8'h0C, (m == 0 || m == 2) ? 8'h00 : {3'b0, itapRef(m), 1'b1}, "R4");
      if (m != 0) push(8'h12, 8'h08, "R5");
      push(8'h00, 8'h00, "R6");
      if (m != 0) push(8'h00, 8'((codeRef(r) << 5) | 8), "R8");
    end
    reqMode = 3'(m); reqRate = 10'(r); reqDrv = 2'(drv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == !skip, "R11", {tag, " busy after start"}, int'(busy), int'(!skip));
    check(error == 1'b0, "R10", {tag, " error cleared on start"}, int'(error), 0);
    if (skip) check(done == 1'b1, "R9", {tag, " skip done"}, int'(done), 1);
    if (poke) begin
      @(negedge clk);
      reqMode = 3'd0; reqRate = 10'd10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 400 && !done; i++) begin
      check(busy == 1'b1, "R11", {tag, " busy while running"}, int'(busy), 1);
      @(negedge clk);
    end
    check(done == 1'b1, "R7", {tag, " done seen"}, int'(done), 1);
    check(busy == 1'b0, "R11", {tag, " busy low at done"}, int'(busy), 0);
    check(error == expErr, "R10", {tag, " error at done"}, int'(error), int'(expErr));
    check(expAddr.size() == 0, "R12", {tag, " writes remaining"}, expAddr.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R11", {tag, " done one cycle"}, int'(done), 0);
    check(error == expErr, "R10", {tag, " error held"}, int'(error), int'(expErr));
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0, "R11", "reset idle", int'({busy, done}), 0);
    check(error == 0 && regWe == 0 && regRe == 0, "R11", "reset port quiet", int'({error, regWe, regRe}), 0);
    runSeq(0, 25, 0, 1'b0, 1'b0, 1'b0, "legacy 25");          // R1 R3 R4 R5 R6
    runSeq(1, 25, 0, 1'b1, 1'b0, 1'b0, "repeat rate");        // R9
    runSeq(1, 50, 0, 1'b0, 1'b0, 1'b0, "HS 50");              // R3 R4 R7 R8
    runSeq(2, 200, 1, 1'b0, 1'b0, 1'b0, "HS200 200");         // R2 R4
    runSeq(4, 100, 2, 1'b0, 1'b0, 1'b0, "HS400 100");         // R2 R8
    runSeq(3, 52, 0, 1'b0, 1'b0, 1'b1, "DDR 52 poked");       // R11 R8
    runSeq(5, 50, 0, 1'b0, 1'b0, 1'b0, "estrobe 50");         // R1
    dllNever = 1'b1;
    runSeq(1, 200, 0, 1'b0, 1'b1, 1'b0, "HS timeout");        // R10
    runSeq(2, 200, 3, 1'b1, 1'b0, 1'b0, "after timeout");     // R10 R9
    runSeq(0, 100, 0, 1'b0, 1'b0, 1'b0, "legacy 100");        // R6
    check(regFile[1] == 8'h4D, "R2", "pad register final", int'(regFile[1]), 8'h4D);
    summary();
  end

endmodule